// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns the addressing mode of a decoded load, store or ALU instruction into the 16-bit operand address the memory access will use. It takes the mode code, the one or two bytes that follow the opcode, the current X and Y index registers and an optional prefix byte. A prefix of 0x18 swaps the indexed base from X to Y. The block also tells the fetch logic how many operand bytes the instruction carries. For inherent and immediate modes it reports that no memory access is needed, and for immediate mode it presents the literal data instead.

All outputs are registered. A request presented with `in_valid` high at one rising clock edge appears on the outputs after that edge, with `out_valid` set. Reset is synchronous and active high.

Top module: `eag_top`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge at which `in_valid` was high, and low otherwise. While `rst` is high at an edge, every output is cleared to zero.
- R2: Mode code 0 (inherent) and the unused codes 5, 6 and 7 give `byte_count` 0, `mem_access` 0, `ea` 0 and `imm_value` 0.
- R3: Mode code 1 (immediate) gives `mem_access` 0 and `ea` 0. When `wide`=1, `imm_value` is {opnd0, opnd1} and `byte_count` is 2. When `wide`=0, `imm_value` is opnd0 zero-extended and `byte_count` is 1. In every other mode `imm_value` is 0.
- R4: Mode code 2 (direct) gives `ea` = {8'h00, opnd0}, `mem_access` 1 and `byte_count` 1.
- R5: Mode code 3 (extended) gives `ea` = {opnd0, opnd1}, with opnd0 as the high byte, `mem_access` 1 and `byte_count` 2.
- R6: Mode code 4 (indexed) with no prefix gives `ea` = X + opnd0. The offset is unsigned, and the sum wraps modulo 2^16. It also gives `mem_access` 1 and `byte_count` 1.
- R7: In indexed mode a prefix of 0x18 makes Y the base. A prefix of 0x1A or 0xCD keeps X as the base. A recognised prefix does not change the outputs of the other modes.
- R8: A prefix present with any other value sets `pre_err` to 1 and forces `mem_access` 0 and `ea` 0. `byte_count` and `imm_value` still follow the mode. `pre_err` is 0 whenever there is no prefix or the prefix is recognised.
- R9: At an edge where `in_valid` is low, `ea`, `mem_access`, `byte_count`, `imm_value` and `pre_err` keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code (0 inh, 1 imm, 2 dir, 3 ext, 4 idx) |
| wide | input | 1 | Immediate operand is two bytes |
| pre_present | input | 1 | A prefix byte preceded the opcode |
| pre_byte | input | 8 | Value of the prefix byte |
| opnd0 | input | 8 | First byte after the opcode |
| opnd1 | input | 8 | Second byte after the opcode |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| out_valid | output | 1 | Result valid |
| ea | output | 16 | Effective operand address |
| mem_access | output | 1 | Operand must be read from or written to memory |
| byte_count | output | 2 | Number of operand bytes after the opcode |
| imm_value | output | 16 | Literal operand for immediate mode |
| pre_err | output | 1 | Unrecognised prefix byte |

## Verification
Base-register selection by the prefix and modulo-2^16 wrap of the indexed sum can both act on the same request. The sweep provokes this by pairing a 0x18 prefix with Y = 0xFFFF and X = 0xFFF0 and nonzero offsets, so the carry out of bit 15 has to be dropped on whichever register the prefix chose. The result is judged against a sum computed in the bench from the register the requirement names. Every mode also meets every prefix value, including an unrecognised one, so the error override is checked in the same cycle as each address form.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    AM_INH = 3'd0,
    AM_IMM = 3'd1,
    AM_DIR = 3'd2,
    AM_EXT = 3'd3,
    AM_IDX = 3'd4
  } amode_e;

  localparam int N_PRE = 3;
  // entry 0 is the code that moves the indexed base to Y
  localparam logic [7:0] PRE_CODES [N_PRE] = '{8'h18, 8'h1A, 8'hCD};

endpackage

// File: rtl/eag_prefix_dec.sv
module eag_prefix_dec #(
  parameter int BYTE_W = 8
) (
  input  logic              present,
  input  logic [BYTE_W-1:0] value,
  output logic              use_y,
  output logic              bad
);
  import eag_pkg::*;

  logic [N_PRE-1:0] hit;

  generate
    for (genvar i = 0; i < N_PRE; i++) begin : g_cmp
      assign hit[i] = present && (value == BYTE_W'(PRE_CODES[i]));
    end
  endgenerate

  assign use_y = hit[0];
  assign bad   = present && (hit == '0);
endmodule

// File: rtl/eag_len.sv
module eag_len (
  input  logic [2:0] mode,
  input  logic       wide,
  output logic [1:0] count
);
  import eag_pkg::*;

  always_comb begin
    case (mode)
      AM_IMM:          count = wide ? 2'd2 : 2'd1;
      AM_DIR, AM_IDX:  count = 2'd1;
      AM_EXT:          count = 2'd2;
      default:         count = 2'd0;
    endcase
  end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc #(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          mode,
  input  logic                wide,
  input  logic                use_y,
  input  logic                bad,
  input  logic [BYTE_W-1:0]   b0,
  input  logic [BYTE_W-1:0]   b1,
  input  logic [2*BYTE_W-1:0] base_x,
  input  logic [2*BYTE_W-1:0] base_y,
  output logic [2*BYTE_W-1:0] ea,
  output logic                access,
  output logic [2*BYTE_W-1:0] imm
);
  import eag_pkg::*;

  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] raw;
  logic              needs_mem;

  assign base = use_y ? base_y : base_x;
  // carry out of the top bit is discarded: wrap modulo 2^ADDR_W
  assign sum  = base + {{BYTE_W{1'b0}}, b0};

  always_comb begin
    raw       = '0;
    needs_mem = 1'b0;
    case (mode)
      AM_DIR: begin raw = {{BYTE_W{1'b0}}, b0}; needs_mem = 1'b1; end
      AM_EXT: begin raw = {b0, b1};             needs_mem = 1'b1; end
      AM_IDX: begin raw = sum;                  needs_mem = 1'b1; end
      default: ;
    endcase
  end

  assign access = needs_mem && !bad;
  assign ea     = access ? raw : '0;

  always_comb begin
    imm = '0;
    if (mode == AM_IMM)
      imm = wide ? {b0, b1} : {{BYTE_W{1'b0}}, b0};
  end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          mode,
  input  logic                wide,
  input  logic                pre_present,
  input  logic [BYTE_W-1:0]   pre_byte,
  input  logic [BYTE_W-1:0]   opnd0,
  input  logic [BYTE_W-1:0]   opnd1,
  input  logic [2*BYTE_W-1:0] idx_x,
  input  logic [2*BYTE_W-1:0] idx_y,
  output logic                out_valid,
  output logic [2*BYTE_W-1:0] ea,
  output logic                mem_access,
  output logic [1:0]          byte_count,
  output logic [2*BYTE_W-1:0] imm_value,
  output logic                pre_err
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic              sel_y, bad_pre, acc_n;
  logic [1:0]        cnt_n;
  logic [ADDR_W-1:0] ea_n, imm_n;

  eag_prefix_dec #(.BYTE_W(BYTE_W)) u_pre (
    .present(pre_present), .value(pre_byte), .use_y(sel_y), .bad(bad_pre)
  );

  eag_len u_len (.mode(mode), .wide(wide), .count(cnt_n));

  eag_addr_calc #(.BYTE_W(BYTE_W)) u_calc (
    .mode(mode), .wide(wide), .use_y(sel_y), .bad(bad_pre),
    .b0(opnd0), .b1(opnd1), .base_x(idx_x), .base_y(idx_y),
    .ea(ea_n), .access(acc_n), .imm(imm_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      mem_access <= 1'b0;
      byte_count <= '0;
      imm_value  <= '0;
      pre_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ea         <= ea_n;
        mem_access <= acc_n;
        byte_count <= cnt_n;
        imm_value  <= imm_n;
        pre_err    <= bad_pre;
      end
    end
  end
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          mode,
  input logic                pre_present,
  input logic [BYTE_W-1:0]   pre_byte,
  input logic [BYTE_W-1:0]   opnd0,
  input logic [BYTE_W-1:0]   opnd1,
  input logic [2*BYTE_W-1:0] idx_x,
  input logic [2*BYTE_W-1:0] idx_y,
  input logic                out_valid,
  input logic [2*BYTE_W-1:0] ea,
  input logic                mem_access,
  input logic [1:0]          byte_count,
  input logic                pre_err
);
  localparam int ADDR_W = 2 * BYTE_W;

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  a_r2_inherent_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0) |=> (!mem_access && byte_count == 2'd0));

  // R4
  a_r4_direct_page0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd2 && !pre_present) |=>
      (ea == {{BYTE_W{1'b0}}, $past(opnd0)} && mem_access));

  // R5
  a_r5_extended_addr: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd3 && !pre_present) |=>
      (ea == {$past(opnd0), $past(opnd1)} && byte_count == 2'd2));

  // R6
  a_r6_indexed_x: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4 && !pre_present) |=>
      (ea == ADDR_W'($past(idx_x) + ADDR_W'($past(opnd0)))));

  // R7
  a_r7_indexed_y: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4 && pre_present && pre_byte == 8'h18) |=>
      (ea == ADDR_W'($past(idx_y) + ADDR_W'($past(opnd0)))));

  // R8
  a_r8_bad_prefix: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pre_present && pre_byte != 8'h18 && pre_byte != 8'h1A &&
     pre_byte != 8'hCD) |=> (pre_err && !mem_access && ea == '0));

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ea) && $stable(mem_access) && $stable(byte_count)));
endmodule

bind eag_top eag_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
  .pre_present(pre_present), .pre_byte(pre_byte), .opnd0(opnd0),
  .opnd1(opnd1), .idx_x(idx_x), .idx_y(idx_y), .out_valid(out_valid),
  .ea(ea), .mem_access(mem_access), .byte_count(byte_count),
  .pre_err(pre_err)
);

// File: tb/sim_eag_top.sv
`timescale 1ns/1ps
module sim_eag_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  mode;
  logic        wide;
  logic        pre_present;
  logic [7:0]  pre_byte, opnd0, opnd1;
  logic [15:0] idx_x, idx_y;
  logic        out_valid, mem_access, pre_err;
  logic [15:0] ea, imm_value;
  logic [1:0]  byte_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .wide(wide),
    .pre_present(pre_present), .pre_byte(pre_byte), .opnd0(opnd0),
    .opnd1(opnd1), .idx_x(idx_x), .idx_y(idx_y), .out_valid(out_valid),
    .ea(ea), .mem_access(mem_access), .byte_count(byte_count),
    .imm_value(imm_value), .pre_err(pre_err)
  );

  task automatic check(string req, logic [15:0] g_ea, logic g_acc, logic [1:0] g_cnt,
                       logic [15:0] g_imm, logic g_err, logic g_v);
    checks++;
    if (ea !== g_ea || mem_access !== g_acc || byte_count !== g_cnt ||
        imm_value !== g_imm || pre_err !== g_err || out_valid !== g_v) begin
      errors++;
      $display("FAIL %s mode=%0d pre=%0b/%h: got ea=%h acc=%b cnt=%0d imm=%h err=%b v=%b exp ea=%h acc=%b cnt=%0d imm=%h err=%b v=%b",
               req, mode, pre_present, pre_byte, ea, mem_access, byte_count,
               imm_value, pre_err, out_valid, g_ea, g_acc, g_cnt, g_imm, g_err, g_v);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  offs [4];
    logic [7:0]  pcode [5];
    logic [15:0] e_ea, e_imm;
    logic [1:0]  e_cnt;
    logic        e_acc, e_err, pp, py;
    string       req;

    offs  = '{8'h00, 8'h7F, 8'hFF, 8'h20};
    pcode = '{8'h00, 8'h18, 8'h1A, 8'hCD, 8'h55};

    rst = 1; in_valid = 1; mode = 3'd3; wide = 1; pre_present = 0;
    pre_byte = 0; opnd0 = 8'hAB; opnd1 = 8'hCD; idx_x = 16'h1111; idx_y = 16'h2222;
    @(posedge clk); @(posedge clk); #1;
    check("R1 reset", 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
    @(negedge clk); rst = 0; in_valid = 0;
    @(posedge clk); #1;
    check("R1 idle after reset", 16'h0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 5; p++)
        for (int w = 0; w < 2; w++)
          for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            in_valid = 1; mode = 3'(m); wide = w[0];
            pp = (p != 0); pre_present = pp; pre_byte = pcode[p];
            opnd0 = offs[d]; opnd1 = ~offs[d] ^ 8'(d * 37);
            idx_x = d[0] ? 16'hFFF0 : 16'h1234;
            idx_y = d[1] ? 16'hFFFF : 16'h8000;
            // expected values from the requirements
            e_err = pp && !(pcode[p] == 8'h18 || pcode[p] == 8'h1A || pcode[p] == 8'hCD);
            py    = pp && pcode[p] == 8'h18;
            e_cnt = (m == 1) ? (w ? 2'd2 : 2'd1) : (m == 2 || m == 4) ? 2'd1 :
                    (m == 3) ? 2'd2 : 2'd0;
            e_imm = (m == 1) ? (w ? {opnd0, opnd1} : {8'h00, opnd0}) : 16'h0;
            e_acc = (m >= 2 && m <= 4) && !e_err;
            e_ea  = 16'h0;
            if (e_acc) begin
              if (m == 2) e_ea = 16'(opnd0);
              else if (m == 3) e_ea = opnd0 * 16'd256 + opnd1;
              else e_ea = 16'(((py ? idx_y : idx_x) + 32'(opnd0)) % 32'h10000);
            end
            if (e_err) req = "R8 bad prefix";
            else if (pp) req = "R7 prefix";
            else if (m == 0 || m > 4) req = "R2 inherent";
            else if (m == 1) req = "R3 immediate";
            else if (m == 2) req = "R4 direct";
            else if (m == 3) req = "R5 extended";
            else req = "R6 indexed";
            @(posedge clk); #1;
            check(req, e_ea, e_acc, e_cnt, e_imm, e_err, 1'b1);
            if (d == 3) begin
              // R9: idle with other inputs changed, outputs hold
              @(negedge clk);
              in_valid = 0; mode = 3'd2; opnd0 = 8'h5A; pre_present = 1; pre_byte = 8'h77;
              @(posedge clk); #1;
              check("R9 hold", e_ea, e_acc, e_cnt, e_imm, e_err, 1'b0);
            end
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule